// File: doc/BRIEF.md
# Register-Accumulator ALU with Flag Registers

This block is the arithmetic and logic unit of a small eight-bit, two-operand controller. The first operand is the destination register's current value, and any result goes back into that register. The second operand is either another register or an eight-bit constant taken from the instruction, chosen by a select input. Each operation is named by a five-bit code from the instruction decoder. The unit returns the result byte and a write-enable for the destination register.

The block keeps two status bits, ZERO and CARRY, in flip-flops. These are updated on the clock edge of each valid operation. The next values are also presented combinationally, so the surrounding sequencer can branch on them in the same cycle.

Besides the usual logic, add and subtract forms, the unit has ten single-bit shifts and rotates. Two further operations, a comparison and a masked bit test, change only the flags and write nothing to the register.

Top module: `aluCore`

## Requirements
- R1: While `rst_n` is low, and after it is released, `zeroFlag` and `carryFlag` read 0.
- R2: With `useImm`=1 the second operand is `immVal`, otherwise it is `regB`. LOAD (code 5'h00) puts the second operand on `result`, asserts `resultWe`, and leaves both flags unchanged.
- R3: AND (5'h01), OR (5'h02) and XOR (5'h03) write the bitwise result. They clear CARRY and set ZERO exactly when the result is 0.
- R4: ADD (5'h04) writes A+B and ADDCY (5'h05) writes A+B+CARRY, both modulo 256. CARRY takes the carry out of bit 7, and ZERO is set when the byte is 0.
- R5: SUB (5'h06) writes A-B and SUBCY (5'h07) writes A-B-CARRY, both modulo 256. CARRY is set on borrow. For SUB, ZERO means the result is 0; for SUBCY, ZERO is (result is 0) AND the previous ZERO.
- R6: COMPARE (5'h08) never asserts `resultWe`. It sets ZERO when A equals B and sets CARRY when A is less than B (unsigned).
- R7: TEST (5'h09) never asserts `resultWe`. It sets ZERO when A AND B is 0 and sets CARRY to the odd parity of A AND B.
- R8: Right shifts move A down one bit, and CARRY takes A[0]. The new bit 7 comes from a different source per code: SR0 (5'h10) uses 0, SR1 (5'h11) uses 1, SRX (5'h12) uses A[7], SRA (5'h13) uses CARRY, and RR (5'h14) uses A[0]. ZERO is set when the result is 0.
- R9: Left shifts move A up one bit, and CARRY takes A[7]. The new bit 0 comes from a different source per code: SL0 (5'h18) uses 0, SL1 (5'h19) uses 1, SLX (5'h1A) uses A[0], SLA (5'h1B) uses CARRY, and RL (5'h1C) uses A[7]. ZERO is set when the result is 0.
- R10: With `opValid` low, `resultWe` is 0, `zeroNext`/`carryNext` equal the stored flags, and the flags do not change at the clock edge. With `opValid` high, the flags take `zeroNext`/`carryNext` at that edge.
- R11: Any code not listed above is a no-op: `resultWe` stays 0 and both flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Execute the presented operation this cycle |
| opCode | input | 5 | Operation code |
| useImm | input | 1 | 1 selects `immVal` as second operand |
| regA | input | 8 | First operand (destination register value) |
| regB | input | 8 | Second register operand |
| immVal | input | 8 | Constant second operand |
| result | output | 8 | Result byte |
| resultWe | output | 1 | Write-enable for the destination register |
| zeroNext | output | 1 | ZERO value after this cycle |
| carryNext | output | 1 | CARRY value after this cycle |
| zeroFlag | output | 1 | Stored ZERO flag |
| carryFlag | output | 1 | Stored CARRY flag |

## Verification
Some properties are checked by assertions on every cycle:
- flags hold while idle and load their next values on a valid operation;
- there is no register write when idle or for the flag-only operations;
- LOAD passes the second operand through untouched;
- every right and left shift sends the outgoing end bit to CARRY;
- the flags are clear under reset.

Other properties can only be shown by the bench's directed scenarios against its own model:
- the arithmetic values;
- the borrow and chained ZERO behaviour of SUBCY;
- the TEST parity;
- each shift's fill source.

These run across random operands with both prior CARRY values.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int DATA_W = 8;
  localparam int OPC_W  = 5;

  localparam logic [OPC_W-1:0] OP_LOAD  = 5'h00;
  localparam logic [OPC_W-1:0] OP_AND   = 5'h01;
  localparam logic [OPC_W-1:0] OP_OR    = 5'h02;
  localparam logic [OPC_W-1:0] OP_XOR   = 5'h03;
  localparam logic [OPC_W-1:0] OP_ADD   = 5'h04;
  localparam logic [OPC_W-1:0] OP_ADDCY = 5'h05;
  localparam logic [OPC_W-1:0] OP_SUB   = 5'h06;
  localparam logic [OPC_W-1:0] OP_SUBCY = 5'h07;
  localparam logic [OPC_W-1:0] OP_CMP   = 5'h08;
  localparam logic [OPC_W-1:0] OP_TEST  = 5'h09;
  localparam logic [OPC_W-1:0] OP_SR0   = 5'h10;
  localparam logic [OPC_W-1:0] OP_SR1   = 5'h11;
  localparam logic [OPC_W-1:0] OP_SRX   = 5'h12;
  localparam logic [OPC_W-1:0] OP_SRA   = 5'h13;
  localparam logic [OPC_W-1:0] OP_RR    = 5'h14;
  localparam logic [OPC_W-1:0] OP_SL0   = 5'h18;
  localparam logic [OPC_W-1:0] OP_SL1   = 5'h19;
  localparam logic [OPC_W-1:0] OP_SLX   = 5'h1A;
  localparam logic [OPC_W-1:0] OP_SLA   = 5'h1B;
  localparam logic [OPC_W-1:0] OP_RL    = 5'h1C;

  typedef enum logic [1:0] {
    UNIT_LOGIC = 2'd0,
    UNIT_ARITH = 2'd1,
    UNIT_SHIFT = 2'd2
  } unitSelE;

  typedef enum logic [1:0] {
    LFN_PASS = 2'd0,
    LFN_AND  = 2'd1,
    LFN_OR   = 2'd2,
    LFN_XOR  = 2'd3
  } logicFnE;

  typedef enum logic [2:0] {
    FILL_ZERO  = 3'd0,
    FILL_ONE   = 3'd1,
    FILL_EXT   = 3'd2,
    FILL_CARRY = 3'd3,
    FILL_ROT   = 3'd4
  } fillSelE;

  typedef struct packed {
    unitSelE unitSel;
    logicFnE logicFn;
    logic    subtract;
    logic    useCarryIn;
    logic    zeroChain;
    logic    parityCarry;
    logic    shiftLeft;
    fillSelE fillSel;
    logic    writeRes;
    logic    updFlags;
  } aluCtrlT;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
#(
  parameter int OPC_BITS = OPC_W
) (
  input  logic [OPC_BITS-1:0] opCode,
  output aluCtrlT             ctrl
);
  always_comb begin
    ctrl             = '0;
    ctrl.unitSel     = UNIT_LOGIC;
    ctrl.logicFn     = LFN_PASS;
    ctrl.fillSel     = FILL_ZERO;
    case (opCode)
      OP_LOAD: begin
        ctrl.writeRes = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl.logicFn  = logicFnE'(opCode[1:0]);
        ctrl.writeRes = 1'b1;
        ctrl.updFlags = 1'b1;
      end
      OP_TEST: begin
        ctrl.logicFn     = LFN_AND;
        ctrl.parityCarry = 1'b1;
        ctrl.updFlags    = 1'b1;
      end
      OP_ADD, OP_ADDCY, OP_SUB, OP_SUBCY: begin
        ctrl.unitSel    = UNIT_ARITH;
        ctrl.subtract   = opCode[1];
        ctrl.useCarryIn = opCode[0];
        ctrl.zeroChain  = opCode[1] & opCode[0];
        ctrl.writeRes   = 1'b1;
        ctrl.updFlags   = 1'b1;
      end
      OP_CMP: begin
        ctrl.unitSel  = UNIT_ARITH;
        ctrl.subtract = 1'b1;
        ctrl.updFlags = 1'b1;
      end
      OP_SR0, OP_SR1, OP_SRX, OP_SRA, OP_RR,
      OP_SL0, OP_SL1, OP_SLX, OP_SLA, OP_RL: begin
        ctrl.unitSel   = UNIT_SHIFT;
        ctrl.shiftLeft = opCode[3];
        ctrl.fillSel   = fillSelE'(opCode[2:0]);
        ctrl.writeRes  = 1'b1;
        ctrl.updFlags  = 1'b1;
      end
      default: begin
        ctrl.writeRes = 1'b0;
        ctrl.updFlags = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opValid,
  input  aluCtrlT          ctrl,
  input  logic             useImm,
  input  logic [WIDTH-1:0] regA,
  input  logic [WIDTH-1:0] regB,
  input  logic [WIDTH-1:0] immVal,
  output logic [WIDTH-1:0] result,
  output logic             resultWe,
  output logic             zeroNext,
  output logic             carryNext,
  output logic             zeroFlag,
  output logic             carryFlag
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opB;
  logic [WIDTH-1:0] logicRes;
  logic             logicCarry;
  logic [WIDTH-1:0] bEff;
  logic             carryIn;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] arithRes;
  logic             arithCarry;
  logic             fillBit;
  logic [WIDTH-1:0] shiftRes;
  logic             shiftCarry;
  logic [WIDTH-1:0] unitRes;
  logic             unitCarry;
  logic             resIsZero;
  logic             zeroCalc;

  assign opB = useImm ? immVal : regB;

  // logic unit
  always_comb begin
    case (ctrl.logicFn)
      LFN_AND: logicRes = regA & opB;
      LFN_OR:  logicRes = regA | opB;
      LFN_XOR: logicRes = regA ^ opB;
      default: logicRes = opB;
    endcase
    logicCarry = ctrl.parityCarry ? ^logicRes : 1'b0;
  end

  // adder shared by add, subtract and compare
  always_comb begin
    bEff = ctrl.subtract ? ~opB : opB;
    if (ctrl.useCarryIn) carryIn = ctrl.subtract ? ~carryFlag : carryFlag;
    else                 carryIn = ctrl.subtract;
    sumWide    = {1'b0, regA} + {1'b0, bEff} + {{WIDTH{1'b0}}, carryIn};
    arithRes   = sumWide[WIDTH-1:0];
    arithCarry = ctrl.subtract ? ~sumWide[WIDTH] : sumWide[WIDTH];
  end

  // single-bit shifter
  always_comb begin
    case (ctrl.fillSel)
      FILL_ONE:   fillBit = 1'b1;
      FILL_EXT:   fillBit = ctrl.shiftLeft ? regA[0] : regA[MSB];
      FILL_CARRY: fillBit = carryFlag;
      FILL_ROT:   fillBit = ctrl.shiftLeft ? regA[MSB] : regA[0];
      default:    fillBit = 1'b0;
    endcase
    if (ctrl.shiftLeft) begin
      shiftRes   = {regA[MSB-1:0], fillBit};
      shiftCarry = regA[MSB];
    end else begin
      shiftRes   = {fillBit, regA[MSB:1]};
      shiftCarry = regA[0];
    end
  end

  always_comb begin
    case (ctrl.unitSel)
      UNIT_ARITH: begin unitRes = arithRes; unitCarry = arithCarry; end
      UNIT_SHIFT: begin unitRes = shiftRes; unitCarry = shiftCarry; end
      default:    begin unitRes = logicRes; unitCarry = logicCarry; end
    endcase
    resIsZero = (unitRes == '0);
    zeroCalc  = ctrl.zeroChain ? (resIsZero & zeroFlag) : resIsZero;
  end

  assign result    = unitRes;
  assign resultWe  = opValid & ctrl.writeRes;
  assign zeroNext  = (opValid & ctrl.updFlags) ? zeroCalc : zeroFlag;
  assign carryNext = (opValid & ctrl.updFlags) ? unitCarry : carryFlag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zeroFlag  <= 1'b0;
      carryFlag <= 1'b0;
    end else if (opValid) begin
      zeroFlag  <= zeroNext;
      carryFlag <= carryNext;
    end
  end
endmodule

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
#(
  parameter int WIDTH    = DATA_W,
  parameter int OPC_BITS = OPC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                opValid,
  input  logic [OPC_BITS-1:0] opCode,
  input  logic                useImm,
  input  logic [WIDTH-1:0]    regA,
  input  logic [WIDTH-1:0]    regB,
  input  logic [WIDTH-1:0]    immVal,
  output logic [WIDTH-1:0]    result,
  output logic                resultWe,
  output logic                zeroNext,
  output logic                carryNext,
  output logic                zeroFlag,
  output logic                carryFlag
);
  aluCtrlT ctrl;

  aluCtrl #(.OPC_BITS(OPC_BITS)) u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .opValid   (opValid),
    .ctrl      (ctrl),
    .useImm    (useImm),
    .regA      (regA),
    .regB      (regB),
    .immVal    (immVal),
    .result    (result),
    .resultWe  (resultWe),
    .zeroNext  (zeroNext),
    .carryNext (carryNext),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag)
  );
endmodule

// File: rtl/aluCoreChk.sv
module aluCoreChk
  import aluPkg::*;
#(
  parameter int WIDTH    = DATA_W,
  parameter int OPC_BITS = OPC_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                opValid,
  input logic [OPC_BITS-1:0] opCode,
  input logic                useImm,
  input logic [WIDTH-1:0]    regA,
  input logic [WIDTH-1:0]    regB,
  input logic [WIDTH-1:0]    immVal,
  input logic [WIDTH-1:0]    result,
  input logic                resultWe,
  input logic                zeroNext,
  input logic                carryNext,
  input logic                zeroFlag,
  input logic                carryFlag
);
  logic [WIDTH-1:0] selB;
  logic             isRight;
  logic             isLeft;
  assign selB    = useImm ? immVal : regB;
  assign isRight = (opCode >= OP_SR0) && (opCode <= OP_RR);
  assign isLeft  = (opCode >= OP_SL0) && (opCode <= OP_RL);

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_flags: assert (!zeroFlag && !carryFlag);
    end
  end

  a_r2_load_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode == OP_LOAD) |->
      (resultWe && result == selB && zeroNext == zeroFlag && carryNext == carryFlag));

  a_r6_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_CMP || opCode == OP_TEST) |-> !resultWe);

  a_r8_right_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && isRight) |-> (carryNext == regA[0] && resultWe));

  a_r9_left_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && isLeft) |-> (carryNext == regA[WIDTH-1] && resultWe));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> (zeroFlag == $past(zeroFlag) && carryFlag == $past(carryFlag)));

  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |-> (!resultWe && zeroNext == zeroFlag && carryNext == carryFlag));

  a_r10_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    opValid |=> (zeroFlag == $past(zeroNext) && carryFlag == $past(carryNext)));
endmodule

bind aluCore aluCoreChk #(.WIDTH(WIDTH), .OPC_BITS(OPC_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opValid   (opValid),
  .opCode    (opCode),
  .useImm    (useImm),
  .regA      (regA),
  .regB      (regB),
  .immVal    (immVal),
  .result    (result),
  .resultWe  (resultWe),
  .zeroNext  (zeroNext),
  .carryNext (carryNext),
  .zeroFlag  (zeroFlag),
  .carryFlag (carryFlag)
);

// File: tb/aluCore_tb.sv
`timescale 1ns/1ps
module aluCore_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = 5'h00;
  logic       useImm = 1'b0;
  logic [7:0] regA = 8'h00;
  logic [7:0] regB = 8'h00;
  logic [7:0] immVal = 8'h00;
  logic [7:0] result;
  logic       resultWe, zeroNext, carryNext, zeroFlag, carryFlag;

  int checkCnt = 0;
  int failCnt  = 0;
  logic mZ = 1'b0;
  logic mC = 1'b0;

  always #4 clk = ~clk;

  aluCore u_dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .useImm(useImm), .regA(regA), .regB(regB), .immVal(immVal),
    .result(result), .resultWe(resultWe), .zeroNext(zeroNext),
    .carryNext(carryNext), .zeroFlag(zeroFlag), .carryFlag(carryFlag)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {we, res[7:0], zero, carry}
  function automatic logic [10:0] refOp(input logic [4:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic z, input logic c);
    logic       we, zn, cn;
    logic [7:0] r;
    logic [8:0] w;
    we = 1'b1; r = 8'h00; zn = z; cn = c;
    case (op)
      5'h00: r = b;
      5'h01: begin r = a & b; zn = (r == 0); cn = 1'b0; end
      5'h02: begin r = a | b; zn = (r == 0); cn = 1'b0; end
      5'h03: begin r = a ^ b; zn = (r == 0); cn = 1'b0; end
      5'h04: begin w = a + b;          r = w[7:0]; cn = w[8]; zn = (r == 0); end
      5'h05: begin w = a + b + 9'(c);  r = w[7:0]; cn = w[8]; zn = (r == 0); end
      5'h06: begin w = {1'b0,a} - {1'b0,b};         r = w[7:0]; cn = w[8]; zn = (r == 0); end
      5'h07: begin w = {1'b0,a} - {1'b0,b} - 9'(c); r = w[7:0]; cn = w[8]; zn = (r == 0) && z; end
      5'h08: begin we = 1'b0; zn = (a == b); cn = (a < b); end
      5'h09: begin we = 1'b0; r = a & b; zn = (r == 0); cn = ^r; end
      5'h10: begin r = {1'b0, a[7:1]}; cn = a[0]; zn = (r == 0); end
      5'h11: begin r = {1'b1, a[7:1]}; cn = a[0]; zn = (r == 0); end
      5'h12: begin r = {a[7], a[7:1]}; cn = a[0]; zn = (r == 0); end
      5'h13: begin r = {c,    a[7:1]}; cn = a[0]; zn = (r == 0); end
      5'h14: begin r = {a[0], a[7:1]}; cn = a[0]; zn = (r == 0); end
      5'h18: begin r = {a[6:0], 1'b0}; cn = a[7]; zn = (r == 0); end
      5'h19: begin r = {a[6:0], 1'b1}; cn = a[7]; zn = (r == 0); end
      5'h1A: begin r = {a[6:0], a[0]}; cn = a[7]; zn = (r == 0); end
      5'h1B: begin r = {a[6:0], c};    cn = a[7]; zn = (r == 0); end
      5'h1C: begin r = {a[6:0], a[7]}; cn = a[7]; zn = (r == 0); end
      default: we = 1'b0;
    endcase
    return {we, r, zn, cn};
  endfunction

  // one valid operation, checked before and after the clock edge
  task automatic doOp(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic imm, input string tag);
    logic [10:0] e;
    logic [7:0]  bSel;
    @(negedge clk);
    opValid = 1'b1; opCode = op; regA = a; useImm = imm;
    if (imm) begin immVal = b; regB = ~b; end
    else     begin regB = b; immVal = ~b; end
    bSel = b;
    e = refOp(op, a, bSel, mZ, mC);
    #1;
    check(resultWe == e[10], {tag, " we"}, int'(resultWe), int'(e[10]));
    if (e[10]) check(result == e[9:2], {tag, " result"}, int'(result), int'(e[9:2]));
    check(zeroNext == e[1], {tag, " zeroNext"}, int'(zeroNext), int'(e[1]));
    check(carryNext == e[0], {tag, " carryNext"}, int'(carryNext), int'(e[0]));
    @(posedge clk); #1;
    check(zeroFlag == e[1], {tag, " zeroFlag"}, int'(zeroFlag), int'(e[1]));
    check(carryFlag == e[0], {tag, " carryFlag"}, int'(carryFlag), int'(e[0]));
    mZ = e[1]; mC = e[0];
    @(negedge clk);
    opValid = 1'b0;
  endtask

  // drive flags to a known pair through SR0
  task automatic setFlags(input logic z, input logic c);
    doOp(5'h10, {6'b0, ~z, c}, 8'h00, 1'b0, "R8 setFlags");
  endtask

  task automatic tReset;
    check(!zeroFlag && !carryFlag, "R1 in reset", int'({zeroFlag, carryFlag}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!zeroFlag && !carryFlag, "R1 after release", int'({zeroFlag, carryFlag}), 0);
  endtask

  task automatic tLoad;
    setFlags(1'b1, 1'b1);
    doOp(5'h00, 8'h3C, 8'h00, 1'b1, "R2 load imm zero");
    setFlags(1'b0, 1'b0);
    doOp(5'h00, 8'hFF, 8'hA5, 1'b0, "R2 load reg");
    doOp(5'h00, 8'h11, 8'h5A, 1'b1, "R2 load imm");
  endtask

  task automatic tLogic;
    for (int i = 0; i < 24; i++) begin
      setFlags(1'b0, 1'b1);
      doOp(5'(5'h01 + i % 3), 8'($urandom), 8'($urandom), 1'(i[0]), "R3 logic");
    end
    setFlags(1'b0, 1'b1);
    doOp(5'h01, 8'hF0, 8'h0F, 1'b0, "R3 and zero");
    doOp(5'h03, 8'h77, 8'h77, 1'b1, "R3 xor zero");
  endtask

  task automatic tArith;
    for (int cin = 0; cin < 2; cin++) begin
      for (int i = 0; i < 40; i++) begin
        setFlags(1'(i % 2), 1'(cin));
        doOp(5'(5'h04 + i % 2), 8'($urandom), 8'($urandom), 1'(i[1]), "R4 add");
        setFlags(1'(i % 2), 1'(cin));
        doOp(5'(5'h06 + i % 2), 8'($urandom), 8'($urandom), 1'(i[1]), "R5 sub");
      end
    end
    setFlags(1'b0, 1'b1);
    doOp(5'h05, 8'hFF, 8'h00, 1'b0, "R4 addcy wrap");
    setFlags(1'b1, 1'b0);
    doOp(5'h06, 8'h42, 8'h42, 1'b0, "R5 sub equal");
    setFlags(1'b0, 1'b1);
    doOp(5'h07, 8'h43, 8'h42, 1'b0, "R5 subcy zero blocked by prior zero");
    setFlags(1'b1, 1'b1);
    doOp(5'h07, 8'h43, 8'h42, 1'b0, "R5 subcy zero chained");
    setFlags(1'b0, 1'b1);
    doOp(5'h07, 8'h00, 8'h00, 1'b1, "R5 subcy borrow");
  endtask

  task automatic tCompareTest;
    for (int i = 0; i < 30; i++) begin
      logic [7:0] a = 8'($urandom);
      logic [7:0] b = (i % 5 == 0) ? a : 8'($urandom);
      setFlags(1'(i[0]), 1'(i[1]));
      doOp(5'h08, a, b, 1'(i[2]), "R6 compare");
      setFlags(1'(i[1]), 1'(i[0]));
      doOp(5'h09, a, b, 1'(i[2]), "R7 test");
    end
    doOp(5'h08, 8'h10, 8'h11, 1'b0, "R6 less");
    doOp(5'h09, 8'h07, 8'h03, 1'b1, "R7 even parity");
  endtask

  task automatic tShifts;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a = (i < 5) ? 8'h01 : ((i < 10) ? 8'h80 : 8'($urandom));
      setFlags(1'b0, 1'(i[3]));
      doOp(5'(5'h10 + i % 5), a, 8'h00, 1'b0, "R8 right shift");
      setFlags(1'b0, 1'(i[3]));
      doOp(5'(5'h18 + i % 5), a, 8'h00, 1'b0, "R9 left shift");
    end
  endtask

  task automatic tHold;
    setFlags(1'b1, 1'b0);
    @(negedge clk);
    opValid = 1'b0; opCode = 5'h04; regA = 8'h01; regB = 8'h01; useImm = 1'b0;
    #1;
    check(!resultWe, "R10 idle we", int'(resultWe), 0);
    check(zeroNext == mZ && carryNext == mC, "R10 idle next",
          int'({zeroNext, carryNext}), int'({mZ, mC}));
    @(posedge clk); #1;
    check(zeroFlag == mZ && carryFlag == mC, "R10 idle hold",
          int'({zeroFlag, carryFlag}), int'({mZ, mC}));
  endtask

  task automatic tUndefined;
    setFlags(1'b0, 1'b1);
    doOp(5'h0A, 8'h00, 8'h00, 1'b0, "R11 undefined 0A");
    setFlags(1'b1, 1'b0);
    doOp(5'h1F, 8'hFF, 8'h01, 1'b1, "R11 undefined 1F");
    doOp(5'h15, 8'h80, 8'h00, 1'b0, "R11 undefined 15");
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #13;
    tReset();
    tLoad();
    tLogic();
    tArith();
    tCompareTest();
    tShifts();
    tHold();
    tUndefined();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule